// File: doc/BRIEF.md
# Three-Wire Potentiometer Host Sequencer

This block drives the three control lines of a 32-position up/down digital potentiometer: an active-low select, an increment strobe and an up/down level. A command carries a direction, a step count and a commit flag, and is passed in over a valid/ready handshake. The sequencer selects the device and sets the direction. It then issues one increment pulse per step, each meeting its low-time and high-time limits. At the end it deselects the device. The level of the increment line at the moment of deselect decides whether the device commits the new position to its nonvolatile store (high) or keeps it only until power is lost (low).

Every timing limit is a parameter counted in system clock cycles. These limits are the select-to-first-edge setup, the direction setup, the direction hold after the strobe returns high, the pulse low and high times, the final-level hold before deselect and the two deselect intervals, one after a commit and one without. The block also keeps a local estimate of the wiper position. The estimate moves by one on every increment falling edge and stops at the two ends, as the device does.

Top module: `potstep_host`

## Requirements
- R1: During and after reset, with no command, `pot_sel_n` is 1, `pot_inc` is 1, `cmd_ready` is 1 and `pos_est` equals HOME_POS.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. For a command that does work, `pot_sel_n` goes to 0 from the next cycle, and `cmd_ready` stays 0 from then until the final deselect interval has ended.
- R3: `pot_up` takes the command's direction (1 = up, 0 = down) in the cycle select falls. `pot_inc` is 1 at that point. The first falling edge of `pot_inc` comes no earlier than max(CYC_SEL_SETUP, CYC_DIR_SETUP) cycles after select falls.
- R4: While selected, `pot_inc` falls exactly `cmd_steps` times. Every low interval between falls lasts at least CYC_INC_LOW cycles, and every high interval lasts at least CYC_INC_HIGH cycles.
- R5: `pot_up` does not change while select is low.
- R6: With the commit flag set, select rises while `pot_inc` is 1. `cmd_ready` then stays 0 for exactly CYC_STORE_GAP cycles of select high.
- R7: With the commit flag clear, select rises while `pot_inc` is 0. `pot_inc` stays 0 for CYC_SKIP_GAP cycles of select high and then returns to 1. `cmd_ready` returns after CYC_SKIP_GAP + CYC_DIR_HOLD cycles of select high.
- R8: The level `pot_inc` has when select rises has been held for at least CYC_FINAL cycles.
- R9: A zero step count with the commit flag set performs a select/deselect cycle with `pot_inc` held high throughout, with no increment edge, followed by the commit interval.
- R10: A zero step count with the commit flag clear is consumed in one cycle. Select and increment do not move, and `cmd_ready` stays 1.
- R11: `pos_est` rises by one on each increment falling edge when `pot_up` is 1 and falls by one when it is 0. It holds at TAPS-1 and at 0 instead of wrapping, and does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_up | input | 1 | Direction: 1 = toward high terminal |
| cmd_steps | input | STEP_W | Number of increment pulses |
| cmd_store | input | 1 | 1 = commit position at deselect |
| pot_sel_n | output | 1 | Active-low device select |
| pot_inc | output | 1 | Increment strobe; falling edge moves the wiper |
| pot_up | output | 1 | Up/down level to the device |
| pos_est | output | $clog2(TAPS) | Local estimate of the wiper position |

## Verification
The assertions assume that reset is held for at least one clock before they are relied on. They also assume the command fields are sampled only on the accepting edge, so changes to `cmd_up`, `cmd_steps` or `cmd_store` at other times have no effect. The stimulus meets both assumptions. It raises `cmd_valid` away from the clock edge only after `cmd_ready` is seen high, drops it one edge later, and waits for `cmd_ready` to return before the next command. The timing parameters are shrunk to a few cycles so that a commit interval fits in a short run. The step counts go past both ends of the 32-position range.

// File: rtl/potstep_pkg.sv
package potstep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_HIGH,
    PH_HOLD,
    PH_GAP,
    PH_REST
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/potstep_timer.sv
module potstep_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0)); // R8

endmodule

// File: rtl/potstep_track.sv
module potstep_track #(
  parameter int TAPS     = 32,
  parameter int HOME_POS = 0,
  localparam int POS_W   = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] TOP  = POS_W'(TAPS - 1);
  localparam logic [POS_W-1:0] HOME = POS_W'(HOME_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= HOME;
    end else if (step) begin
      if (up && pos != TOP) begin
        pos <= pos + 1'b1;
      end else if (!up && pos != '0) begin
        pos <= pos - 1'b1;
      end
    end
  end

  AST_POS_HOLD_TOP: assert property (@(posedge clk) disable iff (rst)
    (step && up && pos == TOP) |=> (pos == TOP)); // R11
  AST_POS_HOLD_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (step && !up && pos == '0) |=> (pos == '0)); // R11
  AST_POS_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos)); // R11

endmodule

// File: rtl/potstep_ctrl.sv
module potstep_ctrl
  import potstep_pkg::*;
#(
  parameter int STEP_W        = 8,
  parameter int CNT_W         = 8,
  parameter int CYC_SEL_SETUP = 2,
  parameter int CYC_DIR_SETUP = 2,
  parameter int CYC_DIR_HOLD  = 2,
  parameter int CYC_INC_LOW   = 2,
  parameter int CYC_INC_HIGH  = 2,
  parameter int CYC_FINAL     = 2,
  parameter int CYC_STORE_GAP = 2,
  parameter int CYC_SKIP_GAP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_store,
  output logic              cmd_ready,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              step,
  output logic              sel_n,
  output logic              inc,
  output logic              up
);

  localparam int SETUP_LEN  = imax(CYC_SEL_SETUP, CYC_DIR_SETUP);
  localparam int LAST_HIGH  = imax(CYC_INC_HIGH, CYC_FINAL);

  phase_t            state, nxt;
  logic [STEP_W-1:0] remain;
  logic              store_q;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    step     = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (cmd_valid && (cmd_steps != '0 || cmd_store)) begin
          nxt      = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETUP_LEN);
        end
      end
      PH_SETUP: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (remain == '0) begin
            nxt     = PH_HOLD;
            tmr_val = CNT_W'(CYC_FINAL);
          end else begin
            nxt     = PH_LOW;
            tmr_val = CNT_W'(CYC_INC_LOW);
            step    = 1'b1;
          end
        end
      end
      PH_LOW: begin
        if (tmr_done) begin
          tmr_load = 1'b1;
          if (remain == '0) begin
            nxt     = PH_HOLD;
            tmr_val = store_q ? CNT_W'(LAST_HIGH) : CNT_W'(CYC_FINAL);
          end else begin
            nxt     = PH_HIGH;
            tmr_val = CNT_W'(CYC_INC_HIGH);
          end
        end
      end
      PH_HIGH: begin
        if (tmr_done) begin
          nxt      = PH_LOW;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(CYC_INC_LOW);
          step     = 1'b1;
        end
      end
      PH_HOLD: begin
        if (tmr_done) begin
          nxt      = PH_GAP;
          tmr_load = 1'b1;
          tmr_val  = store_q ? CNT_W'(CYC_STORE_GAP) : CNT_W'(CYC_SKIP_GAP);
        end
      end
      PH_GAP: begin
        if (tmr_done) begin
          if (store_q) begin
            nxt = PH_IDLE;
          end else begin
            nxt      = PH_REST;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(CYC_DIR_HOLD);
          end
        end
      end
      PH_REST: begin
        if (tmr_done) nxt = PH_IDLE;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PH_IDLE;
      sel_n   <= 1'b1;
      inc     <= 1'b1;
      up      <= 1'b0;
      remain  <= '0;
      store_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == PH_IDLE && nxt == PH_SETUP) begin
        sel_n   <= 1'b0;
        inc     <= 1'b1;
        up      <= cmd_up;
        remain  <= cmd_steps;
        store_q <= cmd_store;
      end
      if (step) begin
        inc    <= 1'b0;
        remain <= remain - 1'b1;
      end
      if (state == PH_LOW && (nxt == PH_HIGH || (nxt == PH_HOLD && store_q))) begin
        inc <= 1'b1;
      end
      if (state == PH_HOLD && nxt == PH_GAP) begin
        sel_n <= 1'b1;
      end
      if (state == PH_GAP && nxt == PH_REST) begin
        inc <= 1'b1;
      end
    end
  end

  assign cmd_ready = (state == PH_IDLE);

  AST_READY_ONLY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !sel_n |-> !cmd_ready); // R2
  AST_SELECT_STARTS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n) |-> inc); // R3
  AST_INC_FALLS_SELECTED: assert property (@(posedge clk) disable iff (rst)
    $fell(inc) |-> (!sel_n && !$past(sel_n))); // R4
  AST_DIR_HELD_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !$past(sel_n)) |-> $stable(up)); // R5
  AST_DESELECT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n) |-> (inc == store_q)); // R6

endmodule

// File: rtl/potstep_host.sv
module potstep_host #(
  parameter int STEP_W        = 8,
  parameter int TAPS          = 32,
  parameter int HOME_POS      = 0,
  parameter int CYC_SEL_SETUP = 13,
  parameter int CYC_DIR_SETUP = 363,
  parameter int CYC_DIR_HOLD  = 13,
  parameter int CYC_INC_LOW   = 125,
  parameter int CYC_INC_HIGH  = 125,
  parameter int CYC_FINAL     = 125,
  parameter int CYC_STORE_GAP = 2500000,
  parameter int CYC_SKIP_GAP  = 13,
  localparam int POS_W        = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_up,
  input  logic [STEP_W-1:0] cmd_steps,
  input  logic              cmd_store,
  output logic              pot_sel_n,
  output logic              pot_inc,
  output logic              pot_up,
  output logic [POS_W-1:0]  pos_est
);
  import potstep_pkg::*;

  localparam int MAX_A   = imax(imax(CYC_SEL_SETUP, CYC_DIR_SETUP), imax(CYC_INC_LOW, CYC_INC_HIGH));
  localparam int MAX_B   = imax(imax(CYC_FINAL, CYC_DIR_HOLD), imax(CYC_STORE_GAP, CYC_SKIP_GAP));
  localparam int MAX_LEN = imax(MAX_A, MAX_B);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             tmr_load, tmr_done, step;
  logic [CNT_W-1:0] tmr_val;

  potstep_ctrl #(
    .STEP_W(STEP_W), .CNT_W(CNT_W),
    .CYC_SEL_SETUP(CYC_SEL_SETUP), .CYC_DIR_SETUP(CYC_DIR_SETUP),
    .CYC_DIR_HOLD(CYC_DIR_HOLD), .CYC_INC_LOW(CYC_INC_LOW),
    .CYC_INC_HIGH(CYC_INC_HIGH), .CYC_FINAL(CYC_FINAL),
    .CYC_STORE_GAP(CYC_STORE_GAP), .CYC_SKIP_GAP(CYC_SKIP_GAP)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_up(cmd_up), .cmd_steps(cmd_steps),
    .cmd_store(cmd_store), .cmd_ready(cmd_ready),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .step(step), .sel_n(pot_sel_n), .inc(pot_inc), .up(pot_up)
  );

  potstep_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  potstep_track #(.TAPS(TAPS), .HOME_POS(HOME_POS)) u_track (
    .clk(clk), .rst(rst), .step(step), .up(pot_up), .pos(pos_est)
  );

endmodule

// File: tb/tb_potstep_host.sv
module tb_potstep_host;

  localparam int STEP_W = 8;
  localparam int TAPS   = 32;
  localparam int SSU = 3, DSU = 5, DHOLD = 2, LOWC = 4, HIGHC = 3;
  localparam int FIN = 6, SGAP = 20, KGAP = 2;
  localparam int SETUP_LEN = (SSU > DSU) ? SSU : DSU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_up = 1'b0, cmd_store = 1'b0;
  logic [STEP_W-1:0] cmd_steps = '0;
  logic cmd_ready, pot_sel_n, pot_inc, pot_up;
  logic [4:0] pos_est;

  always #4 clk = ~clk;

  potstep_host #(
    .STEP_W(STEP_W), .TAPS(TAPS), .HOME_POS(0),
    .CYC_SEL_SETUP(SSU), .CYC_DIR_SETUP(DSU), .CYC_DIR_HOLD(DHOLD),
    .CYC_INC_LOW(LOWC), .CYC_INC_HIGH(HIGHC), .CYC_FINAL(FIN),
    .CYC_STORE_GAP(SGAP), .CYC_SKIP_GAP(KGAP)
  ) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_up(cmd_up), .cmd_steps(cmd_steps), .cmd_store(cmd_store),
    .pot_sel_n(pot_sel_n), .pot_inc(pot_inc), .pot_up(pot_up), .pos_est(pos_est)
  );

  typedef struct packed {
    logic [15:0] pulses;
    logic        store;
    logic        up;
    logic [7:0]  pos;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0, model_pos = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // monitor: measures the line waveform and compares with queued expectations
  logic prev_sel = 1'b1, prev_inc = 1'b1, win_up = 1'b0;
  int run_len = 0, pulses = 0, gap_cnt = 0, gap_inclow = 0;
  bit first_seen = 0, gap_on = 0, gap_store = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!pot_sel_n) begin
        if (prev_sel) begin
          run_len = 1; pulses = 0; first_seen = 0; win_up = pot_up;
          chk(pot_inc == 1'b1, "R3 inc high at select", pot_inc, 1);
        end else begin
          chk(pot_up == win_up, "R5 dir stable", pot_up, win_up);
          if (pot_inc == prev_inc) begin
            run_len++;
          end else begin
            if (prev_inc) begin
              if (!first_seen) chk(run_len >= SETUP_LEN, "R3 setup", run_len, SETUP_LEN);
              else chk(run_len >= HIGHC, "R4 high time", run_len, HIGHC);
              first_seen = 1;
              pulses++;
            end else begin
              chk(run_len >= LOWC, "R4 low time", run_len, LOWC);
            end
            run_len = 1;
          end
        end
        if (cmd_ready) chk(0, "R2 ready low while selected", cmd_ready, 0);
      end else if (!prev_sel) begin
        chk(run_len >= FIN, "R8 final hold", run_len, FIN);
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected select cycle", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(pulses == int'(e.pulses), "R4 pulse count", pulses, int'(e.pulses));
          chk(pot_inc == e.store, e.store ? "R6 level at deselect" : "R7 level at deselect",
              pot_inc, e.store);
          chk(win_up == e.up, "R3 direction", win_up, e.up);
          chk(int'(pos_est) == int'(e.pos), "R11 position", pos_est, int'(e.pos));
          gap_on = 1; gap_store = e.store; gap_cnt = 1; gap_inclow = pot_inc ? 0 : 1;
        end
      end else if (gap_on) begin
        if (!cmd_ready) begin
          gap_cnt++;
          if (!pot_inc) gap_inclow++;
        end else begin
          gap_on = 0;
          if (gap_store) begin
            chk(gap_cnt == SGAP, "R6 commit gap", gap_cnt, SGAP);
          end else begin
            chk(gap_cnt == KGAP + DHOLD, "R7 skip gap", gap_cnt, KGAP + DHOLD);
            chk(gap_inclow == KGAP, "R7 inc low after deselect", gap_inclow, KGAP);
          end
        end
      end
      prev_sel = pot_sel_n;
      prev_inc = pot_inc;
    end
  end

  // driver: issues one command and queues what the monitor must see
  task automatic send(input bit up, input int steps, input bit store);
    exp_t e;
    int p0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    p0 = model_pos;
    for (int i = 0; i < steps; i++) begin
      if (up && model_pos < TAPS - 1) model_pos++;
      else if (!up && model_pos > 0) model_pos--;
    end
    if (steps != 0 || store) begin
      e.pulses = 16'(steps); e.store = store; e.up = up; e.pos = 8'(model_pos);
      exp_q.push_back(e);
    end
    cmd_valid = 1'b1; cmd_up = up; cmd_steps = STEP_W'(steps); cmd_store = store;
    @(posedge clk);
    #1 cmd_valid = 1'b0; cmd_up = ~up; cmd_steps = '1; cmd_store = ~store;
    @(negedge clk);
    if (steps == 0 && !store) begin
      for (int k = 0; k < 6; k++) begin
        chk(pot_sel_n && pot_inc && cmd_ready, "R10 no-op keeps lines idle",
            {pot_sel_n, pot_inc, cmd_ready}, 7);
        @(negedge clk);
      end
      chk(int'(pos_est) == p0, "R10 no-op position", pos_est, p0);
    end else begin
      chk(!cmd_ready && !pot_sel_n, "R2 busy after accept", {cmd_ready, pot_sel_n}, 0);
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(0, "watchdog expired", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pot_sel_n && pot_inc && cmd_ready, "R1 reset lines", {pot_sel_n, pot_inc, cmd_ready}, 7);
    chk(pos_est == 5'd0, "R1 reset position", pos_est, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pot_sel_n && pot_inc && cmd_ready, "R1 idle after reset", {pot_sel_n, pot_inc, cmd_ready}, 7);

    send(1'b1, 5, 1'b1);   // commit, up
    send(1'b0, 2, 1'b0);   // skip, down
    send(1'b1, 40, 1'b1);  // past top end: R11 saturation
    send(1'b1, 1, 1'b0);   // at top, stays
    send(1'b0, 50, 1'b0);  // past bottom end
    send(1'b0, 3, 1'b1);   // at bottom, stays
    send(1'b1, 0, 1'b1);   // R9 store-only cycle
    send(1'b1, 0, 1'b0);   // R10 no-op
    send(1'b1, 1, 1'b0);
    send(1'b0, 1, 1'b1);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all cycles observed", exp_q.size(), 0);
    finish_run();
  end

endmodule